// File: doc/BRIEF.md
# Control Setup Packet Capture

This block sits behind the endpoint-0 packet receiver of a USB device controller. The receiver delivers the data bytes of a setup transaction one per cycle, framed by a start strobe and an end strobe that carries the error-free verdict. When exactly eight bytes arrive and the verdict is good, the block copies them into eight read-only byte registers. It then raises a setup-ready flag, which also drives the interrupt line. A packet that is short, long or bad leaves the stored request untouched.

The local processor reads the eight bytes over a byte-wide read port. It then clears setup-ready by writing a one to the status address. The block remembers which of the eight bytes have been read since the most recent capture. A clear is refused until all eight have been read, so a request that arrives while firmware is still reading is never lost. The block also decodes the stored request into a two-bit hint that tells firmware which control flow follows.

Top module: `setup_capture`

## Requirements
- R1: The eight stored bytes read back at addresses D0h through D7h in arrival order: request type, request, value low, value high, index low, index high, length low, length high. Read data appears on `rd_data` on the clock edge that samples `rd_en` and holds until the next read.
- R2: A read of the status address (default E0h) returns setup-ready in bit 0, the stage hint in bits 2:1 and zero in bits 7:3. A read of any other address returns zero.
- R3: `setup_rdy` and `irq` go high on the clock edge that samples `rx_end` with `rx_ok` high, provided exactly eight `rx_valid` bytes followed the last `rx_start`. The new bytes become readable on that same edge.
- R4: While all eight bytes have been read since the last capture, a write to the status address with `wr_bit` = 1 clears `setup_rdy` and `irq` on that edge. A write with `wr_bit` = 0, or a write to any other address, changes nothing.
- R5: A packet with fewer than eight bytes, more than eight bytes, or `rx_ok` low at `rx_end` changes neither the stored bytes nor `setup_rdy`.
- R6: `stage_hint` is 00 when the stored length is zero. It is 01 when the length is nonzero and request-type bit 7 is 0, and 10 when the length is nonzero and bit 7 is 1.
- R7: A clear write is refused, and `setup_rdy` stays high, while any of the eight bytes is unread since the most recent capture. Each capture marks all eight bytes unread again, even bytes read from the previous request.
- R8: When a capture and a clear write fall in the same cycle, the capture wins: `setup_rdy` stays high, the new bytes are stored and all eight are marked unread.
- R9: After reset, `setup_rdy`, `irq`, `rd_data` and all stored bytes are zero, and `stage_hint` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_start | input | 1 | Start of a setup data packet; restarts the byte count |
| rx_valid | input | 1 | A received data byte is present on rx_data |
| rx_data | input | 8 | Received data byte |
| rx_end | input | 1 | End of packet; never in the same cycle as rx_valid |
| rx_ok | input | 1 | Packet verdict, sampled with rx_end (1 = error-free) |
| rd_en | input | 1 | Processor read strobe |
| rd_addr | input | 8 | Processor read address |
| rd_data | output | 8 | Registered read data |
| wr_en | input | 1 | Processor write strobe |
| wr_addr | input | 8 | Processor write address |
| wr_bit | input | 1 | Bit 0 of the write data (1 requests a clear) |
| setup_rdy | output | 1 | Setup-ready status flag |
| irq | output | 1 | Setup-ready interrupt request |
| stage_hint | output | 2 | Decoded control flow of the stored request |

## Verification
Two events can collide on one clock edge: the end of a good setup packet and a processor clear of setup-ready. The bench first reads all eight bytes of a pending request, so the clear on its own would be accepted. It then places the clear write in exactly the cycle that carries `rx_end` of a new good packet. Afterwards it requires `setup_rdy` still high and the new bytes readable. It also requires that a second clear, issued with no further reads, is refused, which shows that the read tracking was reset by the winning capture.

// File: rtl/setup_capture_pkg.sv
package setup_capture_pkg;

  typedef enum logic [1:0] {
    FLOW_NODATA = 2'b00,
    FLOW_WRITE  = 2'b01,
    FLOW_READ   = 2'b10
  } flow_e;

  function automatic flow_e decode_flow(input logic [7:0] req_type,
                                        input logic [7:0] len_lo,
                                        input logic [7:0] len_hi);
    if ((len_lo | len_hi) == 8'h00) return FLOW_NODATA;
    else if (req_type[7])           return FLOW_READ;
    else                            return FLOW_WRITE;
  endfunction

endpackage

// File: rtl/setup_rx_assembler.sv
module setup_rx_assembler #(
  parameter int NB = 8,
  parameter int DW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rx_start,
  input  logic           rx_valid,
  input  logic [DW-1:0]  rx_data,
  input  logic           rx_end,
  input  logic           rx_ok,
  output logic           commit,
  output logic [NB*DW-1:0] stage_flat
);
  localparam int CW = $clog2(NB + 1);
  localparam logic [CW-1:0] FULL = CW'(NB);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (rx_start) begin
      cnt_d = '0;
      ovf_d = 1'b0;
    end else if (rx_valid) begin
      if (cnt_q == FULL) ovf_d = 1'b1;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  for (genvar i = 0; i < NB; i++) begin : g_slot
    logic          slot_en;
    logic [DW-1:0] slot_q;
    assign slot_en = rx_valid && !rx_start && (cnt_q == CW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_en) slot_q <= rx_data;
    end
    assign stage_flat[i*DW +: DW] = slot_q;
  end

  assign commit = rx_end && rx_ok && (cnt_q == FULL) && !ovf_q;

endmodule

// File: rtl/setup_reg_file.sv
module setup_reg_file #(
  parameter int          NB        = 8,
  parameter int          DW        = 8,
  parameter int          AW        = 8,
  parameter logic [7:0]  BASE_ADDR = 8'hD0,
  parameter logic [7:0]  STAT_ADDR = 8'hE0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [NB*DW-1:0] stage_flat,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  input  logic [DW-1:0]    stat_byte,
  output logic [DW-1:0]    rd_data,
  output logic [NB*DW-1:0] regs_flat,
  output logic [NB-1:0]    read_mask
);
  logic [NB*DW-1:0] regs_q;
  logic [NB-1:0]    mask_q, mask_d, hit;
  logic [DW-1:0]    rdq, rdd, byte_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      regs_q <= '0;
    else if (commit) regs_q <= stage_flat;
  end

  for (genvar i = 0; i < NB; i++) begin : g_hit
    assign hit[i] = rd_en && (rd_addr == AW'(BASE_ADDR + i));
  end

  always_comb begin
    byte_sel = '0;
    for (int i = 0; i < NB; i++) begin
      if (hit[i]) byte_sel = regs_q[i*DW +: DW];
    end
  end

  always_comb begin
    mask_d = commit ? '0 : (mask_q | hit);
    rdd    = rdq;
    if (rd_en) begin
      if (|hit)                        rdd = byte_sel;
      else if (rd_addr == AW'(STAT_ADDR)) rdd = stat_byte;
      else                             rdd = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      rdq    <= '0;
    end else begin
      mask_q <= mask_d;
      rdq    <= rdd;
    end
  end

  assign rd_data   = rdq;
  assign regs_flat = regs_q;
  assign read_mask = mask_q;

endmodule

// File: rtl/setup_ready_ctrl.sv
module setup_ready_ctrl #(
  parameter int         AW        = 8,
  parameter logic [7:0] STAT_ADDR = 8'hE0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic          all_read,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_bit,
  output logic          ready
);
  logic rdy_q, rdy_d, clr_req;

  assign clr_req = wr_en && wr_bit && (wr_addr == AW'(STAT_ADDR));

  always_comb begin
    rdy_d = rdy_q;
    if (commit)                    rdy_d = 1'b1;
    else if (clr_req && all_read)  rdy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= rdy_d;
  end

  assign ready = rdy_q;

endmodule

// File: rtl/setup_capture.sv
module setup_capture
  import setup_capture_pkg::*;
#(
  parameter int         NB        = 8,
  parameter int         DW        = 8,
  parameter int         AW        = 8,
  parameter logic [7:0] BASE_ADDR = 8'hD0,
  parameter logic [7:0] STAT_ADDR = 8'hE0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_start,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_end,
  input  logic          rx_ok,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_bit,
  output logic          setup_rdy,
  output logic          irq,
  output logic [1:0]    stage_hint
);
  logic             commit_w;
  logic [NB*DW-1:0] stage_w, regs_w;
  logic [NB-1:0]    mask_w;
  logic             rdy_w;
  flow_e            flow_w;
  logic [DW-1:0]    stat_w;

  setup_rx_assembler #(.NB(NB), .DW(DW)) u_asm (
    .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_end(rx_end), .rx_ok(rx_ok),
    .commit(commit_w), .stage_flat(stage_w)
  );

  setup_reg_file #(.NB(NB), .DW(DW), .AW(AW), .BASE_ADDR(BASE_ADDR),
                   .STAT_ADDR(STAT_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .commit(commit_w), .stage_flat(stage_w),
    .rd_en(rd_en), .rd_addr(rd_addr), .stat_byte(stat_w), .rd_data(rd_data),
    .regs_flat(regs_w), .read_mask(mask_w)
  );

  setup_ready_ctrl #(.AW(AW), .STAT_ADDR(STAT_ADDR)) u_rdy (
    .clk(clk), .rst_n(rst_n), .commit(commit_w), .all_read(&mask_w),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_bit(wr_bit), .ready(rdy_w)
  );

  // byte 0 = request type, bytes 6/7 = length low/high
  assign flow_w     = decode_flow(regs_w[0 +: 8], regs_w[6*DW +: 8], regs_w[7*DW +: 8]);
  assign stat_w     = {{(DW-3){1'b0}}, flow_w, rdy_w};
  assign stage_hint = flow_w;
  assign setup_rdy  = rdy_w;
  assign irq        = rdy_w;

endmodule

// File: rtl/setup_capture_chk.sv
module setup_capture_chk #(
  parameter int         NB        = 8,
  parameter int         DW        = 8,
  parameter int         AW        = 8,
  parameter logic [7:0] STAT_ADDR = 8'hE0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_end,
  input logic             rx_ok,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic             wr_bit,
  input logic             setup_rdy,
  input logic             irq,
  input logic [1:0]       stage_hint,
  input logic             commit,
  input logic [NB-1:0]    read_mask,
  input logic [NB*DW-1:0] regs_flat
);
  logic clr_w;
  assign clr_w = wr_en && wr_bit && (wr_addr == AW'(STAT_ADDR));

  a_r3_rise_needs_good_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(setup_rdy) |-> $past(rx_end && rx_ok));

  a_r3_irq_follows_ready: assert property (@(posedge clk) disable iff (!rst_n)
    irq == setup_rdy);

  a_r4_clear_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_rdy && clr_w && (&read_mask) && !commit) |=> !setup_rdy);

  a_r5_bad_end_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_end && !rx_ok) |=> $stable(regs_flat));

  a_r6_hint_legal: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stage_hint));

  a_r7_clear_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_rdy && clr_w && !(&read_mask)) |=> setup_rdy);

  a_r8_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (setup_rdy && read_mask == '0));

endmodule

bind setup_capture setup_capture_chk #(.NB(NB), .DW(DW), .AW(AW), .STAT_ADDR(STAT_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_end(rx_end), .rx_ok(rx_ok), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_bit(wr_bit), .setup_rdy(setup_rdy), .irq(irq),
  .stage_hint(stage_hint), .commit(commit_w), .read_mask(mask_w),
  .regs_flat(regs_w)
);

// File: tb/setup_capture_test.sv
module setup_capture_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_start = 0, rx_valid = 0, rx_end = 0, rx_ok = 0;
  logic [7:0] rx_data = 0;
  logic rd_en = 0, wr_en = 0, wr_bit = 0;
  logic [7:0] rd_addr = 0, wr_addr = 0;
  logic [7:0] rd_data;
  logic setup_rdy, irq;
  logic [1:0] stage_hint;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [63:0] shadow = 64'h0;

  always #2 clk = ~clk;

  setup_capture uut (
    .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_end(rx_end), .rx_ok(rx_ok), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_bit(wr_bit), .setup_rdy(setup_rdy), .irq(irq), .stage_hint(stage_hint)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_flow(input logic [63:0] p);
    if (p[63:48] == 16'h0) return 2'b00;
    return p[7] ? 2'b10 : 2'b01;
  endfunction

  // n bytes of p (a ninth byte is AAh), then rx_end with verdict ok; optional clear at end
  task automatic send(input logic [63:0] p, input int n, input bit ok, input bit clr);
    @(negedge clk); rx_start = 1;
    @(negedge clk); rx_start = 0;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1; rx_data = (i < 8) ? p[i*8 +: 8] : 8'hAA;
      @(negedge clk);
    end
    rx_valid = 0; rx_end = 1; rx_ok = ok;
    if (clr) begin wr_en = 1; wr_addr = 8'hE0; wr_bit = 1; end
    @(negedge clk);
    rx_end = 0; rx_ok = 0; wr_en = 0; wr_bit = 0;
    if (ok && n == 8) shadow = p;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic wr(input logic [7:0] a, input logic b);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_bit = b;
    @(negedge clk); wr_en = 0; wr_bit = 0;
  endtask

  task automatic read_all(input string tag);
    logic [7:0] d;
    for (int i = 0; i < 8; i++) begin
      rd(8'hD0 + 8'(i), d);
      chk(tag, d, shadow[i*8 +: 8]);
    end
  endtask

  task automatic t_reset;
    chk("R9 ready", setup_rdy, 0);
    chk("R9 irq", irq, 0);
    chk("R9 hint", stage_hint, 2'b00);
    chk("R9 rd_data", rd_data, 0);
    read_all("R9 stored byte");
  endtask

  task automatic t_capture_read;
    logic [7:0] d;
    send(64'h0012_0000_0100_0680, 8, 1, 0);
    chk("R3 ready", setup_rdy, 1);
    chk("R3 irq", irq, 1);
    chk("R6 read flow", stage_hint, exp_flow(shadow));
    read_all("R1 byte order");
    rd(8'hE0, d);
    chk("R2 status", d, {5'b0, 2'b10, 1'b1});
    rd(8'h55, d);
    chk("R2 unmapped", d, 0);
  endtask

  task automatic t_clear_ok;
    logic [7:0] d;
    wr(8'hE0, 0);
    chk("R4 zero write ignored", setup_rdy, 1);
    wr(8'hE1, 1);
    chk("R4 other address ignored", setup_rdy, 1);
    wr(8'hE0, 1);
    chk("R4 clear", setup_rdy, 0);
    chk("R4 irq", irq, 0);
    rd(8'hE0, d);
    chk("R2 status cleared", d, {5'b0, 2'b10, 1'b0});
  endtask

  task automatic t_bad_packets;
    logic [63:0] keep;
    keep = shadow;
    send(64'h1111_2222_3333_4444, 5, 1, 0);
    chk("R5 short ready", setup_rdy, 0);
    send(64'h5555_6666_7777_8888, 9, 1, 0);
    chk("R5 long ready", setup_rdy, 0);
    send(64'h9999_AAAA_BBBB_CCCC, 8, 0, 0);
    chk("R5 error ready", setup_rdy, 0);
    chk("R5 hint", stage_hint, exp_flow(keep));
    read_all("R5 bytes kept");
  endtask

  task automatic t_refuse;
    logic [7:0] d;
    send(64'h0000_0000_0001_0900, 8, 1, 0);
    chk("R6 nodata flow", stage_hint, 2'b00);
    rd(8'hD0, d); rd(8'hD1, d); rd(8'hD2, d);
    wr(8'hE0, 1);
    chk("R7 partial read refused", setup_rdy, 1);
    rd(8'hD3, d); rd(8'hD4, d); rd(8'hD5, d); rd(8'hD6, d);
    send(64'h0007_0002_0000_0A21, 8, 1, 0);
    chk("R6 write flow", stage_hint, 2'b01);
    rd(8'hD7, d);
    chk("R7 new byte", d, 8'h00);
    wr(8'hE0, 1);
    chk("R7 refused after overwrite", setup_rdy, 1);
    read_all("R7 bytes");
    wr(8'hE0, 1);
    chk("R7 full read accepted", setup_rdy, 0);
  endtask

  task automatic t_collide;
    send(64'h0040_0000_0000_0681, 8, 1, 0);
    read_all("R8 prep");
    send(64'h0002_0001_0000_00A1, 8, 1, 1);
    chk("R8 ready held", setup_rdy, 1);
    chk("R8 hint", stage_hint, 2'b10);
    wr(8'hE0, 1);
    chk("R8 mask reset", setup_rdy, 1);
    read_all("R8 new bytes");
    wr(8'hE0, 1);
    chk("R8 final clear", setup_rdy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_capture_read();
    t_clear_ok();
    t_bad_packets();
    t_refuse();
    t_collide();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule